// File: doc/BRIEF.md
# Receive Datapath Enable Controller

This block decides whether a packet receive path may accept frames. Software drives an enable bit and owns the consume side of a circular descriptor ring. The block owns the produce side. It reports one status bit that is high while the receive path is active. Frames arrive through a start/done handshake: a start is accepted only while the controller is listening, and the done pulse marks the cycle in which the frame and its status are committed. On that cycle the produce index advances.

The controller has three states. OFF is inactive. LISTEN is active and waiting for a frame. RECV is active with a frame in progress. The named transitions are:

- T_ENABLE: OFF to LISTEN, when the enable bit is high and the ring is not full.
- T_DISABLE: LISTEN to OFF, when the enable bit is low.
- T_FULL: LISTEN to OFF, when the ring is full.
- T_ACCEPT: LISTEN to RECV, on an accepted start.
- T_COMMIT_STAY: RECV to LISTEN, on done, when the enable bit is still high and the ring will not be full after the commit.
- T_COMMIT_STOP: RECV to OFF, on done in any other case.
- T_SOFT: any state to OFF, with the produce index cleared. This happens on a synchronous soft reset.

Clearing the enable bit during a frame therefore takes effect only after that frame is committed. The ring size is programmable as "last index" (ring size minus one), and both the produce index and the full test wrap at that value.

Top module: `rx_gate_ctrl`

## Requirements
- R1: After the asynchronous hardware reset, rx_active is 0, frm_accept is 0 and prod_idx is 0.
- R2: In OFF with rx_en high and the ring not full, rx_active becomes 1 one clock later (T_ENABLE). With rx_en low, the controller stays in OFF.
- R3: In LISTEN with rx_en low, rx_active becomes 0 one clock later (T_DISABLE).
- R4: If rx_en goes low during a frame, rx_active stays 1 until the done pulse. The commit still advances prod_idx, and rx_active is 0 one clock after the done pulse (T_COMMIT_STOP).
- R5: The ring is full when prod_idx equals (cons_idx - 1) modulo (ring_last + 1). While the ring is full the controller is in OFF, or it leaves LISTEN or RECV for OFF at the next state update. When the ring stops being full because cons_idx changed, the controller returns to LISTEN only if rx_en is high.
- R6: A done pulse in RECV advances prod_idx by one one clock later, going from ring_last to 0. A done pulse in OFF or LISTEN leaves prod_idx unchanged.
- R7: frm_accept is 1 exactly when the controller is in LISTEN, rx_en is high, the ring is not full and frm_start is high. A start in OFF has no effect: rx_active stays 0 and a following done pulse does not move prod_idx.
- R8: A soft_rst pulse, in any state and also during a frame, gives rx_active 0 and prod_idx 0 one clock later. The controller then stays inactive until T_ENABLE applies.
- R9: rx_active is 1 in LISTEN and RECV and 0 in OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, same effect as hardware reset |
| rx_en | input | 1 | Software receive enable |
| ring_last | input | IW | Last valid ring index (ring size minus one), at least 1 |
| cons_idx | input | IW | Consume index written by software, at most ring_last |
| frm_start | input | 1 | Start of an incoming frame |
| frm_done | input | 1 | Frame and its status committed |
| frm_accept | output | 1 | The start on this cycle is taken |
| rx_active | output | 1 | Receive status, 1 when active |
| prod_idx | output | IW | Produce index |

## Verification
For every ring size from two to eight entries and for every consume position, the ring is filled from index zero. The bench checks that exactly (cons - 1) mod size frames are accepted and that the status falls on the commit that fills the ring. This separates off-by-one errors in the full test from wrap errors. Separate sequences check the following:
- Disabling while idle differs from disabling during a frame.
- Done and start pulses outside their legal states have no effect.
- Freeing the ring with the enable high differs from freeing it with the enable low.
- A soft reset during a frame clears the produce index.
A wrap sequence moves the produce index from the last index to zero.

// File: rtl/rx_gate_pkg.sv
package rx_gate_pkg;

    typedef enum logic [1:0] {
        RXG_OFF    = 2'd0,
        RXG_LISTEN = 2'd1,
        RXG_RECV   = 2'd2
    } rxg_state_t;

endpackage

// File: rtl/rxg_ring_track.sv
module rxg_ring_track #(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          commit,
    input  logic [IW-1:0] ring_last,
    input  logic [IW-1:0] cons_idx,
    output logic [IW-1:0] prod_idx,
    output logic          ring_full,
    output logic          full_after_commit
);

    localparam logic [IW-1:0] IDX_ZERO = '0;
    localparam logic [IW-1:0] IDX_ONE  = IW'(1);

    logic [IW-1:0] prod_q;
    logic [IW-1:0] prod_step;
    logic [IW-1:0] cons_prev;

    // Next ring position, wrapping after the last index.
    always_comb begin
        if (prod_q == ring_last) prod_step = IDX_ZERO;
        else                     prod_step = prod_q + IDX_ONE;
    end

    // Position just behind the consumer, modulo ring size.
    always_comb begin
        if (cons_idx == IDX_ZERO) cons_prev = ring_last;
        else                      cons_prev = cons_idx - IDX_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        prod_q <= IDX_ZERO;
        else if (soft_rst) prod_q <= IDX_ZERO;
        else if (commit)   prod_q <= prod_step;
    end

    assign prod_idx          = prod_q;
    assign ring_full         = (prod_q == cons_prev);
    assign full_after_commit = (prod_step == cons_prev);

endmodule

// File: rtl/rxg_fsm.sv
module rxg_fsm
    import rx_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       rx_en,
    input  logic       ring_full,
    input  logic       full_after_commit,
    input  logic       frm_start,
    input  logic       frm_done,
    output rxg_state_t state,
    output logic       frm_accept,
    output logic       commit,
    output logic       rx_active
);

    rxg_state_t state_q;
    rxg_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = RXG_OFF;
        end else begin
            unique case (state_q)
                RXG_OFF: begin
                    if (rx_en && !ring_full) state_d = RXG_LISTEN;
                end
                RXG_LISTEN: begin
                    if (!rx_en || ring_full) state_d = RXG_OFF;
                    else if (frm_start)      state_d = RXG_RECV;
                end
                RXG_RECV: begin
                    if (frm_done) begin
                        if (rx_en && !full_after_commit) state_d = RXG_LISTEN;
                        else                             state_d = RXG_OFF;
                    end
                end
                default: state_d = RXG_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RXG_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        frm_accept = 1'b0;
        commit     = 1'b0;
        rx_active  = 1'b0;
        unique case (state_q)
            RXG_OFF: begin
                rx_active = 1'b0;
            end
            RXG_LISTEN: begin
                rx_active  = 1'b1;
                frm_accept = frm_start && rx_en && !ring_full && !soft_rst;
            end
            RXG_RECV: begin
                rx_active = 1'b1;
                commit    = frm_done && !soft_rst;
            end
            default: rx_active = 1'b0;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/rx_gate_ctrl.sv
module rx_gate_ctrl
    import rx_gate_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          rx_en,
    input  logic [IW-1:0] ring_last,
    input  logic [IW-1:0] cons_idx,
    input  logic          frm_start,
    input  logic          frm_done,
    output logic          frm_accept,
    output logic          rx_active,
    output logic [IW-1:0] prod_idx
);

    rxg_state_t state;
    logic       commit;
    logic       ring_full;
    logic       full_after_commit;

    rxg_ring_track #(.IW(IW)) u_ring (
        .clk               (clk),
        .rst_n             (rst_n),
        .soft_rst          (soft_rst),
        .commit            (commit),
        .ring_last         (ring_last),
        .cons_idx          (cons_idx),
        .prod_idx          (prod_idx),
        .ring_full         (ring_full),
        .full_after_commit (full_after_commit)
    );

    rxg_fsm u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .soft_rst          (soft_rst),
        .rx_en             (rx_en),
        .ring_full         (ring_full),
        .full_after_commit (full_after_commit),
        .frm_start         (frm_start),
        .frm_done          (frm_done),
        .state             (state),
        .frm_accept        (frm_accept),
        .commit            (commit),
        .rx_active         (rx_active)
    );

endmodule

// File: rtl/rx_gate_chk.sv
module rx_gate_chk
    import rx_gate_pkg::*;
#(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          rx_en,
    input logic          frm_done,
    input logic          frm_accept,
    input logic          rx_active,
    input logic          ring_full,
    input logic [IW-1:0] ring_last,
    input logic [IW-1:0] prod_idx,
    input rxg_state_t    state
);

    logic [IW-1:0] prev_next;
    assign prev_next = (prod_idx == ring_last) ? '0 : prod_idx + IW'(1);

    // R2
    enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RXG_OFF && rx_en && !ring_full && !soft_rst) |=> rx_active);

    // R3
    disable_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RXG_LISTEN && !rx_en && !soft_rst) |=> !rx_active);

    // R4
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RXG_RECV && !frm_done && !soft_rst) |=> rx_active);

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RXG_LISTEN && ring_full) |=> !rx_active);

    // R6
    prod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst) |=> (prod_idx == $past(prod_idx) || prod_idx == $past(prev_next)));

    // R7
    accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_accept |-> (rx_active && rx_en && !ring_full));

    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!rx_active && prod_idx == '0));

endmodule

bind rx_gate_ctrl rx_gate_chk #(.IW(IW)) u_rx_gate_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .rx_en      (rx_en),
    .frm_done   (frm_done),
    .frm_accept (frm_accept),
    .rx_active  (rx_active),
    .ring_full  (ring_full),
    .ring_last  (ring_last),
    .prod_idx   (prod_idx),
    .state      (state)
);

// File: tb/rx_gate_ctrl_bench.sv
`timescale 1ns/100ps
module rx_gate_ctrl_bench;

    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          rx_en = 1'b0;
    logic [IW-1:0] ring_last = IW'(7);
    logic [IW-1:0] cons_idx = '0;
    logic          frm_start = 1'b0;
    logic          frm_done = 1'b0;
    logic          frm_accept;
    logic          rx_active;
    logic [IW-1:0] prod_idx;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_gate_ctrl #(.IW(IW)) u_rx_gate_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .rx_en      (rx_en),
        .ring_last  (ring_last),
        .cons_idx   (cons_idx),
        .frm_start  (frm_start),
        .frm_done   (frm_done),
        .frm_accept (frm_accept),
        .rx_active  (rx_active),
        .prod_idx   (prod_idx)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_soft_reset();
        rx_en = 1'b0;
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
    endtask

    // One accepted frame: start pulse, then done pulse.
    task automatic run_frame(input string tag);
        frm_start = 1'b1;
        #1;
        check_val({tag, " R7 accept"}, int'(frm_accept), 1);
        step();
        frm_start = 1'b0;
        frm_done = 1'b1;
        step();
        frm_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int n;
        int exp_frames;
        int p;
        #12;
        check_val("R1 active at reset", int'(rx_active), 0);
        check_val("R1 prod at reset", int'(prod_idx), 0);
        check_val("R1 accept at reset", int'(frm_accept), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();

        // R7 / R6: start and done while OFF are ignored
        frm_start = 1'b1;
        #1;
        check_val("R7 accept in OFF", int'(frm_accept), 0);
        step();
        frm_start = 1'b0;
        frm_done = 1'b1;
        step();
        frm_done = 1'b0;
        check_val("R7 active after start in OFF", int'(rx_active), 0);
        check_val("R6 done in OFF no step", int'(prod_idx), 0);
        step();
        check_val("R2 stays off with enable low", int'(rx_active), 0);

        // R2 / R9: enable
        ring_last = IW'(7);
        cons_idx = '0;
        rx_en = 1'b1;
        step();
        check_val("R2 R9 active after enable", int'(rx_active), 1);

        // R6: done while LISTEN is ignored
        frm_done = 1'b1;
        step();
        frm_done = 1'b0;
        check_val("R6 done in LISTEN no step", int'(prod_idx), 0);

        // R3: disable while listening
        rx_en = 1'b0;
        step();
        check_val("R3 off after disable", int'(rx_active), 0);

        // R4: disable during frame
        rx_en = 1'b1;
        step();
        frm_start = 1'b1;
        step();
        frm_start = 1'b0;
        rx_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            check_val("R4 active while draining", int'(rx_active), 1);
        end
        frm_done = 1'b1;
        step();
        frm_done = 1'b0;
        check_val("R4 commit prod", int'(prod_idx), 1);
        check_val("R4 off after commit", int'(rx_active), 0);

        // R5 / R6 / R9: sweep ring sizes and consume positions
        for (int last = 1; last <= 7; last++) begin
            n = last + 1;
            for (int c = 0; c <= last; c++) begin
                do_soft_reset();
                ring_last = IW'(last);
                cons_idx = IW'(c);
                rx_en = 1'b1;
                step();
                exp_frames = (c + n - 1) % n;
                check_val("R5 R9 active after enable in sweep", int'(rx_active),
                          (exp_frames > 0) ? 1 : 0);
                for (int k = 0; k < exp_frames; k++) begin
                    run_frame("sweep");
                    check_val("R6 sweep prod", int'(prod_idx), k + 1);
                    check_val("R5 sweep active", int'(rx_active),
                              (k + 1 < exp_frames) ? 1 : 0);
                end
                frm_start = 1'b1;
                #1;
                check_val("R5 R7 no accept when full", int'(frm_accept), 0);
                frm_start = 1'b0;
                step();
                check_val("R5 stays off when full", int'(rx_active), 0);
            end
        end

        // R5 / R6: wrap with ring_last = 3, and recovery from full
        do_soft_reset();
        ring_last = IW'(3);
        cons_idx = '0;
        rx_en = 1'b1;
        step();
        for (int k = 0; k < 3; k++) run_frame("wrap fill");
        check_val("R5 full at last index", int'(rx_active), 0);
        check_val("R6 prod at last index", int'(prod_idx), 3);
        rx_en = 1'b0;
        cons_idx = IW'(2);
        step();
        step();
        check_val("R5 no return with enable low", int'(rx_active), 0);
        rx_en = 1'b1;
        step();
        check_val("R5 return when freed", int'(rx_active), 1);
        run_frame("wrap");
        p = (3 + 1) % 4;
        check_val("R6 prod wraps to zero", int'(prod_idx), p);
        check_val("R6 active after wrap", int'(rx_active), 1);
        run_frame("wrap refill");
        check_val("R6 prod after wrap", int'(prod_idx), 1);
        check_val("R5 full again", int'(rx_active), 0);

        // R8: soft reset during a frame
        do_soft_reset();
        ring_last = IW'(7);
        cons_idx = '0;
        rx_en = 1'b1;
        step();
        run_frame("pre soft");
        frm_start = 1'b1;
        step();
        frm_start = 1'b0;
        rx_en = 1'b0;
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        check_val("R8 active after soft reset", int'(rx_active), 0);
        check_val("R8 prod after soft reset", int'(prod_idx), 0);
        frm_done = 1'b1;
        step();
        frm_done = 1'b0;
        check_val("R8 stale done ignored", int'(prod_idx), 0);
        check_val("R8 stays off", int'(rx_active), 0);
        rx_en = 1'b1;
        step();
        check_val("R8 re-enable", int'(rx_active), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule